// File: doc/BRIEF.md
# Keyed Two-Write Watchdog Timer

This block is a watchdog timer behind one 32-bit control word with a write enable for each byte lane. Software cannot change or service the timer with a single store. A first write must carry an arming pattern in the low byte. The next write, of any kind, is then the only one that can change the timer. Once armed, the register goes back to unarmed after that second write, whatever it contains.

On the second write, the byte lanes that are enabled decide what is taken from the data bus and what is rebuilt from stored copies. The live prescaler/enable setting and the live down-counter can each be loaded from the bus or from the stored settings and the stored reload value. Servicing the watchdog is therefore a second write that touches only the low byte: the timer restarts from its stored reload value and its setting stays the same.

The counter moves down by one on each prescaled tick, at a rate of one step every 2^n clocks. When it reaches zero it raises a timeout pulse for one cycle, and it then stays at zero until something reloads it.

Top module: `armwd_top`

## Requirements
- R1: After synchronous reset, the read word is 0xFFFF0000 (stored reload all ones, both enables clear, unarmed), `count` is 0 and `timeout` is low.
- R2: While unarmed, a write arms the register only if lane 0 is enabled and bits 7:0 equal 0x55. Any other write while unarmed changes nothing. The armed flag reads back in bit 6 of the read word.
- R3: Any write made while armed returns the register to unarmed, whatever its byte enables or data. A following write that is not an arming write has no effect.
- R4: A read (`rd_en`) does not advance and does not cancel the arming state. After any number of reads, the next write is still treated as the second write.
- R5: A second write counts as "key written" only if lane 0 is enabled and bits 7:0 equal 0xAA. If it is not key written, the live setting, the counter, the stored setting and the stored reload all keep their values.
- R6: A key-written second write without lane 1 reloads the live setting from the stored setting and the counter from the stored reload value. The stored fields are unchanged.
- R7: A key-written second write with lane 1 but without both lanes 2 and 3 loads the live setting and the stored setting from the bus. The counter reloads from the stored reload value, and the stored reload is unchanged.
- R8: A key-written second write with all of lanes 1, 2 and 3 loads the live setting, the stored setting, the stored reload and the counter from the bus.
- R9: Field layout on write: bit 15 is enable, bits 11:8 are the prescaler select n, and bits 31:16 are the reload value. Read word layout: [31:16] stored reload, [15] live enable, [11:8] live select, [7] stored enable, [6] armed, [3:0] stored select, other bits 0. The read data is registered and valid in the cycle after `rd_en`.
- R10: While enabled, the counter decrements once every 2^n clocks, and the first decrement comes 2^n clocks after the load. While disabled, it holds its value.
- R11: When a decrement takes the counter from 1 to 0, `timeout` is high for exactly one cycle, in the same cycle that `count` first reads 0. The counter then stays at 0 with no further pulse. Loading 0 gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_be | input | 4 | Byte-lane write enables, bit i for data bits 8i+7:8i |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; `rd_data` is updated at the next edge |
| rd_data | output | 32 | Registered read word |
| count | output | 16 | Live counter value |
| timeout | output | 1 | One-cycle pulse when the counter reaches zero |

## Verification
All 16 byte-enable patterns are applied to the second write against a counter that is running, with the bus holding a setting and a reload value that differ from the stored ones. The counter value just after the write shows whether it was reloaded from the bus, from the stored reload value, or not at all. The read word shows which setting fields moved. Keys close to the two patterns (0x54, 0x56, the other pattern) and arming writes with lane 0 masked show that only exact keys are accepted. Sweeps over prescaler selects 0 to 3 with reloads 1 to 3, plus one run at the largest select, compare every cycle against the arithmetic step schedule and pulse position. Disabled, zero-load and post-timeout cases show that the counter holds.

// File: rtl/armwd_pkg.sv
package armwd_pkg;
  localparam int PSEL_W  = 4;
  localparam int CNT_W   = 16;
  localparam int REL_LSB = 16;
  localparam int RES_LSB = 8;
  localparam int EN_BIT  = 15;

  typedef struct packed {
    logic              en;
    logic [PSEL_W-1:0] psel;
  } res_t;

  typedef struct packed {
    logic load_act;
    logic act_bus;
    logic load_cnt;
    logic cnt_bus;
    logic st_res_we;
    logic st_rel_we;
  } upd_t;

  function automatic upd_t lane_rules(input logic key_ok, input logic [3:0] be);
    upd_t u;
    u = '0;
    if (key_ok) begin
      u.load_act = 1'b1;
      u.load_cnt = 1'b1;
      if (be[1]) begin
        u.act_bus   = 1'b1;
        u.st_res_we = 1'b1;
        if (be[2] && be[3]) begin
          u.cnt_bus   = 1'b1;
          u.st_rel_we = 1'b1;
        end
      end
    end
    return u;
  endfunction
endpackage

// File: rtl/armwd_arm.sv
module armwd_arm
  import armwd_pkg::*;
#(
  parameter logic [7:0] KEY_ARM  = 8'h55,
  parameter logic [7:0] KEY_FIRE = 8'hAA
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [3:0] wr_be,
  input  logic [7:0] key_byte,
  output logic       armed,
  output upd_t       upd
);
  logic arm_hit, fire_hit;

  assign arm_hit  = wr_be[0] && (key_byte == KEY_ARM);
  assign fire_hit = wr_be[0] && (key_byte == KEY_FIRE);

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else if (wr_en) armed <= armed ? 1'b0 : arm_hit;
  end

  always_comb begin
    upd = '0;
    if (wr_en && armed) upd = lane_rules(fire_hit, wr_be);
  end
endmodule

// File: rtl/armwd_fields.sv
module armwd_fields
  import armwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  upd_t             upd,
  input  res_t             bus_res,
  input  logic [CNT_W-1:0] bus_rel,
  input  logic             rd_en,
  input  logic             armed,
  output res_t             act,
  output logic [CNT_W-1:0] st_rel,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic [31:0]      rd_data
);
  res_t        st_res;
  logic [31:0] word;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_res <= '0;
      act    <= '0;
      st_rel <= '1;
    end else begin
      if (upd.st_res_we) st_res <= bus_res;
      if (upd.st_rel_we) st_rel <= bus_rel;
      if (upd.load_act)  act    <= upd.act_bus ? bus_res : st_res;
    end
  end

  assign cnt_load = upd.load_cnt;
  assign cnt_val  = upd.cnt_bus ? bus_rel : st_rel;

  always_comb begin
    word = '0;
    word[REL_LSB +: CNT_W]  = st_rel;
    word[EN_BIT]            = act.en;
    word[RES_LSB +: PSEL_W] = act.psel;
    word[7]                 = st_res.en;
    word[6]                 = armed;
    word[0 +: PSEL_W]       = st_res.psel;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= word;
  end
endmodule

// File: rtl/armwd_tick.sv
module armwd_tick #(
  parameter int PSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PSEL_W-1:0] psel,
  input  logic              restart,
  output logic              tick
);
  localparam int PRE_W = (1 << PSEL_W) - 1;

  logic [PRE_W-1:0] pre, mask;

  for (genvar b = 0; b < PRE_W; b++) begin : g_mask
    assign mask[b] = (32'(psel) > b);
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !en) pre <= '0;
    else pre <= pre + 1'b1;
  end

  assign tick = en && ((pre & mask) == mask);
endmodule

// File: rtl/armwd_count.sv
module armwd_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             timeout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (load) count <= load_val;
      else if (tick && count != '0) begin
        count <= count - 1'b1;
        if (count == CNT_W'(1)) timeout <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/armwd_top.sv
module armwd_top
  import armwd_pkg::*;
#(
  parameter logic [7:0] KEY_ARM  = 8'h55,
  parameter logic [7:0] KEY_FIRE = 8'hAA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [3:0]       wr_be,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  output logic [31:0]      rd_data,
  output logic [CNT_W-1:0] count,
  output logic             timeout
);
  logic             armed_w, cnt_load, tick;
  upd_t             upd;
  res_t             act, bus_res;
  logic [CNT_W-1:0] st_rel_w, cnt_val, bus_rel;

  assign bus_res = '{en: wr_data[EN_BIT], psel: wr_data[RES_LSB +: PSEL_W]};
  assign bus_rel = wr_data[REL_LSB +: CNT_W];

  armwd_arm #(.KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)) u_arm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be),
    .key_byte(wr_data[7:0]), .armed(armed_w), .upd(upd)
  );

  armwd_fields u_fields (
    .clk(clk), .rst(rst), .upd(upd), .bus_res(bus_res), .bus_rel(bus_rel),
    .rd_en(rd_en), .armed(armed_w), .act(act), .st_rel(st_rel_w),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .rd_data(rd_data)
  );

  armwd_tick #(.PSEL_W(PSEL_W)) u_tick (
    .clk(clk), .rst(rst), .en(act.en), .psel(act.psel),
    .restart(cnt_load), .tick(tick)
  );

  armwd_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val),
    .tick(tick), .count(count), .timeout(timeout)
  );
endmodule

// File: rtl/armwd_chk.sv
module armwd_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic             armed,
  input logic [CNT_W-1:0] count,
  input logic             timeout,
  input logic [CNT_W-1:0] st_rel
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !timeout); // R11
  AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    timeout |-> (count == '0)); // R11
  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !wr_en) |=> (count == '0)); // R11
  AST_SECOND_DISARMS: assert property (@(posedge clk) disable iff (rst)
    (armed && wr_en) |=> !armed); // R3
  AST_READ_KEEPS_ARM: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en) |=> (armed == $past(armed))); // R4
  AST_ARM_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !armed) |=> $stable(st_rel)); // R2
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && count != '0) |=> (count == $past(count) || count == $past(count) - 1'b1)); // R10
endmodule

bind armwd_top armwd_chk #(.CNT_W(armwd_pkg::CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .armed(armed_w),
  .count(count), .timeout(timeout), .st_rel(st_rel_w)
);

// File: tb/armwd_top_test.sv
module armwd_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [15:0] count;
  logic        timeout;
  int checks = 0, errs = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  armwd_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .count(count), .timeout(timeout)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_be = '0; wr_data = '0;
  endtask

  task automatic do_rd(output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic prog(input logic en, input logic [3:0] ps, input logic [15:0] rel);
    do_wr(4'b0001, 32'h0000_0055);
    do_wr(4'b1111, {rel, en, 3'b000, ps, 8'hAA});
  endtask

  function automatic logic [31:0] word(input logic [15:0] rel, input logic aen,
      input logic [3:0] aps, input logic sen, input logic arm, input logic [3:0] sps);
    return {rel, aen, 3'b000, aps, sen, arm, 2'b00, sps};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0] keys [5];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", 32'(count), 32'h0);
    chk("R1 timeout", 32'(timeout), 32'h0);
    do_rd(v);
    chk("R1 read word", v, 32'hFFFF_0000);

    // R2 only exact key with lane 0 arms
    keys = '{8'h00, 8'h54, 8'h56, 8'hAA, 8'hFF};
    foreach (keys[k]) begin
      do_wr(4'b1111, {24'h0, keys[k]});
      do_rd(v);
      chk("R2 wrong key no arm", 32'(v[6]), 32'h0);
    end
    do_wr(4'b1110, 32'h0000_0055);
    do_rd(v);
    chk("R2 lane0 masked no arm", 32'(v[6]), 32'h0);
    chk("R2 fields untouched", v, 32'hFFFF_0000);
    do_wr(4'b0001, 32'h0000_0055);
    do_rd(v);
    chk("R2 armed flag bit6", 32'(v[6]), 32'h1);

    // R3 any write disarms, next write then ignored
    do_wr(4'b0000, 32'h0);
    do_rd(v);
    chk("R3 disarm on empty write", 32'(v[6]), 32'h0);
    do_wr(4'b1111, 32'h1111_85AA);
    do_rd(v);
    chk("R3 unarmed fire ignored", v, 32'hFFFF_0000);
    do_wr(4'b0001, 32'h0000_0055);
    do_wr(4'b1110, 32'h2222_8100);
    do_rd(v);
    chk("R3 disarm lanes 1-3 only", v, 32'hFFFF_0000);

    // R4 reads keep the armed state
    do_wr(4'b0001, 32'h0000_0055);
    do_rd(v); chk("R4 armed after read", 32'(v[6]), 32'h1);
    do_rd(v); chk("R4 armed after 2nd read", 32'(v[6]), 32'h1);
    do_wr(4'b1111, 32'h0042_0AAA);
    chk("R4 second write applied count", 32'(count), 32'h42);
    do_rd(v);
    chk("R4 R9 word after full write", v, word(16'h0042, 1'b0, 4'hA, 1'b0, 1'b0, 4'hA));

    // R5 R6 R7 R8 all byte-enable patterns on the second write
    for (int be = 0; be < 16; be++) begin
      prog(1'b1, 4'h0, 16'h1234);
      do_wr(4'b0001, 32'h0000_0055);
      do_wr(4'(be), 32'h5A5A_81AA);
      if (!be[0]) begin
        chk("R5 no key count not reloaded", 32'(count < 16'h1234 && count > 16'h1200), 32'h1);
        do_rd(v);
        chk("R5 no key fields", v, word(16'h1234, 1'b1, 4'h0, 1'b1, 1'b0, 4'h0));
      end else if (!be[1]) begin
        chk("R6 count from stored reload", 32'(count), 32'h1234);
        do_rd(v);
        chk("R6 fields from stored", v, word(16'h1234, 1'b1, 4'h0, 1'b1, 1'b0, 4'h0));
      end else if (!(be[2] && be[3])) begin
        chk("R7 count from stored reload", 32'(count), 32'h1234);
        do_rd(v);
        chk("R7 setting from bus", v, word(16'h1234, 1'b1, 4'h1, 1'b1, 1'b0, 4'h1));
      end else begin
        chk("R8 count from bus", 32'(count), 32'h5A5A);
        do_rd(v);
        chk("R8 all from bus", v, word(16'h5A5A, 1'b1, 4'h1, 1'b1, 1'b0, 4'h1));
      end
    end
    // R5 lane 0 written with a wrong key
    prog(1'b1, 4'h0, 16'h1234);
    do_wr(4'b0001, 32'h0000_0055);
    do_wr(4'b1111, 32'h5A5A_8155);
    chk("R5 bad key count not reloaded", 32'(count < 16'h1234 && count > 16'h1200), 32'h1);
    do_rd(v);
    chk("R5 bad key fields", v, word(16'h1234, 1'b1, 4'h0, 1'b1, 1'b0, 4'h0));

    // R10 R11 step schedule sweep
    for (int ps = 0; ps < 4; ps++) begin
      for (int rv = 1; rv <= 3; rv++) begin
        prog(1'b1, 4'(ps), 16'(rv));
        for (int i = 0; i <= (rv << ps) + 2; i++) begin
          int steps;
          steps = i >> ps;
          chk("R10 count schedule", 32'(count), (steps >= rv) ? 32'h0 : 32'(rv - steps));
          chk("R11 timeout position", 32'(timeout), (i == (rv << ps)) ? 32'h1 : 32'h0);
          @(negedge clk);
        end
      end
    end
    // R10 largest select
    prog(1'b1, 4'hF, 16'h0001);
    repeat (32767) @(negedge clk);
    chk("R10 psel15 before step", 32'(count), 32'h1);
    chk("R11 psel15 no early pulse", 32'(timeout), 32'h0);
    @(negedge clk);
    chk("R10 psel15 step", 32'(count), 32'h0);
    chk("R11 psel15 pulse", 32'(timeout), 32'h1);
    @(negedge clk);
    chk("R11 pulse one cycle", 32'(timeout), 32'h0);
    repeat (5) @(negedge clk);
    chk("R11 hold at zero", 32'(count), 32'h0);
    // R10 disabled holds
    prog(1'b0, 4'h2, 16'h0009);
    repeat (20) @(negedge clk);
    chk("R10 disabled holds", 32'(count), 32'h9);
    // R11 loading zero gives no pulse
    prog(1'b1, 4'h0, 16'h0000);
    for (int i = 0; i < 5; i++) begin
      chk("R11 zero load no pulse", 32'(timeout), 32'h0);
      @(negedge clk);
    end
    chk("R11 zero load count", 32'(count), 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule